// File: doc/BRIEF.md
# Single-Fetch Page Table Entry Refill Engine

This block services a translation lookaside buffer miss with one memory read. When a lookup misses, the engine takes the faulting virtual address and forms the virtual address of the matching page table entry. It does this by adding a page-table base register to the faulting page number, scaled to four bytes per entry. The page table is one linear array of four-byte entries that spans a 4 MiB window of virtual space. The base register is aligned to 4 MiB.

The entry address is itself a virtual address, so it is first translated through the same TLB at ring-0 privilege. If that translation hits, the engine issues a single read at ring 0 to the returned physical address. A good response is written into the auto-refill way, and the engine then signals that the original access should restart.

If the entry address does not translate, no read is made. Instead the engine raises a TLB-miss exception, or a double exception when the requester was already in exception mode. A read that returns an error raises a load-error exception. Permission checks on the restarted access belong to the normal lookup path, not to this engine.

Top module: `pte_refill_engine`

## Requirements
- R1: Out of reset `miss_ready` is 1 and every pulse output (`tlb_wr_en`, `restart`, `exc_tlb_miss`, `exc_double`, `exc_load_err`), `lk_req` and `mem_req_valid` are 0. `miss_ready` is 1 only while the engine is idle, and it returns to 1 in the cycle after the final pulse of a refill.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. In the next cycle `lk_req` is 1, `lk_ring` is 0, and `lk_vaddr` equals `pte_base + ((miss_vaddr >> 10) & ~3)`, using the base sampled at acceptance.
- R3: When the lookup hits, exactly one read is issued. It goes to `lk_paddr` with `mem_ring` 0, and `mem_req_valid` and `mem_addr` are held until `mem_req_ready` is 1.
- R4: When the lookup misses and the accepted `miss_excm` was 0, no read is issued. `exc_tlb_miss` is 1 for exactly one cycle, the cycle after the lookup.
- R5: When the lookup misses and the accepted `miss_excm` was 1, `exc_double` pulses for one cycle in place of `exc_tlb_miss`. `miss_excm` has no effect when the lookup hits.
- R6: A response with `mem_rsp_err` 0 is handled in two steps. In the next cycle `tlb_wr_en` pulses with `tlb_wr_pte` equal to the response data and `tlb_wr_vaddr` equal to the faulting address with its low 12 bits cleared. In the cycle after that, `restart` pulses.
- R7: A response with `mem_rsp_err` 1 pulses `exc_load_err` in the next cycle. It produces no TLB write and no restart.
- R8: While busy, `miss_ready` is 0. Changes on `miss_valid`, `miss_vaddr`, `miss_excm` and `pte_base` have no effect on the refill in progress.
- R9: A memory response that arrives while no read is outstanding is ignored. It causes no TLB write and no exception.
- R10: At most one of `tlb_wr_en`, `restart`, `exc_tlb_miss`, `exc_double` and `exc_load_err` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | TLB miss request |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_excm | input | 1 | Requester is already in exception mode |
| miss_ready | output | 1 | Engine idle, request can be taken |
| pte_base | input | 32 | Page-table base register, 4 MiB aligned |
| lk_req | output | 1 | Lookup of the entry address is active |
| lk_vaddr | output | 32 | Virtual address of the page table entry |
| lk_ring | output | 2 | Privilege ring for the lookup, always 0 |
| lk_hit | input | 1 | Lookup hit, same cycle |
| lk_paddr | input | 32 | Translated physical address, same cycle |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | 32 | Read physical address |
| mem_ring | output | 2 | Privilege ring of the read, always 0 |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read response carries an error |
| mem_rsp_data | input | 32 | Fetched page table entry |
| tlb_wr_en | output | 1 | Write the fetched entry into the auto-refill way |
| tlb_wr_vaddr | output | 32 | Page address being filled |
| tlb_wr_pte | output | 32 | Entry written |
| restart | output | 1 | Retry the original access |
| exc_tlb_miss | output | 1 | Entry address did not translate |
| exc_double | output | 1 | Same miss while in exception mode |
| exc_load_err | output | 1 | Entry read returned an error |

## Verification
The bench goes after six corner cases.

- The entry address is checked at the top of the address space, at address zero and under a non-zero base. A design that skipped the clearing of the low two bits, or shifted by the wrong amount, would present a misaligned or wrong lookup address.
- Miss outcomes are checked with the exception-mode flag both clear and set. An engine that ignored the flag would raise the plain miss exception where a double exception belongs. An engine that tried a read after a miss would show up in the count of accepted reads.
- Delayed request acceptance and delayed responses are checked. An engine that dropped its request early, or issued a second read, would be caught.
- Error responses are checked. A design that wrote the TLB anyway would produce a TLB write.
- New requests held high during a refill are checked. A design that resampled its inputs would refill the wrong page.
- A response that arrives while no read is outstanding is checked. A design that did not gate on an outstanding read would write a stray TLB entry.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_XLATE   = 3'd1,
    ST_FETCH   = 3'd2,
    ST_AWAIT   = 3'd3,
    ST_WRITE   = 3'd4,
    ST_RESTART = 3'd5,
    ST_FAULT   = 3'd6
  } prf_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_TLB    = 2'd1,
    CAUSE_DOUBLE = 2'd2,
    CAUSE_LOAD   = 2'd3
  } prf_cause_e;

endpackage

// File: rtl/prf_addr_gen.sv
// Forms the virtual address of the page table entry that maps a faulting address.
module prf_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PAGE_LOG2  = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] fault_vaddr,
  output logic [VA_W-1:0] pte_vaddr,
  output logic [VA_W-1:0] page_vaddr
);
  localparam int          VPN_W     = VA_W - PAGE_LOG2;
  localparam logic [VA_W-1:0] PAGE_MASK = {{VPN_W{1'b1}}, {PAGE_LOG2{1'b0}}};

  logic [VA_W-1:0] vpn;
  logic [VA_W-1:0] entry_offset;

  always_comb begin
    vpn          = fault_vaddr >> PAGE_LOG2;
    entry_offset = vpn << ENTRY_LOG2;
    pte_vaddr    = base + entry_offset;
    page_vaddr   = fault_vaddr & PAGE_MASK;
  end
endmodule

// File: rtl/prf_capture.sv
// Holds the request context and the intermediate results of a refill.
module prf_capture
  import prf_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic             miss_excm,
  input  logic [VA_W-1:0]  pte_base,
  input  logic             paddr_en,
  input  logic [PA_W-1:0]  lk_paddr,
  input  logic             pte_en,
  input  logic [PTE_W-1:0] rsp_data,
  input  logic             cause_en,
  input  prf_cause_e       cause_d,
  output logic [VA_W-1:0]  vaddr_q,
  output logic             excm_q,
  output logic [VA_W-1:0]  base_q,
  output logic [PA_W-1:0]  paddr_q,
  output logic [PTE_W-1:0] pte_q,
  output prf_cause_e       cause_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      excm_q  <= 1'b0;
      base_q  <= '0;
    end else if (accept) begin
      vaddr_q <= miss_vaddr;
      excm_q  <= miss_excm;
      base_q  <= pte_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
    end else if (paddr_en) begin
      paddr_q <= lk_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (pte_en) begin
      pte_q <= rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/prf_ctrl.sv
// Sequencer: lookup of the entry address, one read, fill, restart or fault.
module prf_ctrl
  import prf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       miss_valid,
  input  logic       lk_hit,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  input  logic       mem_rsp_err,
  input  logic       excm_q,
  output prf_state_e state_q,
  output logic       accept,
  output logic       paddr_en,
  output logic       pte_en,
  output logic       cause_en,
  output prf_cause_e cause_d
);
  prf_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    paddr_en = 1'b0;
    pte_en   = 1'b0;
    cause_en = 1'b0;
    cause_d  = CAUSE_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (miss_valid) begin
          accept  = 1'b1;
          state_d = ST_XLATE;
        end
      end
      ST_XLATE: begin
        if (lk_hit) begin
          paddr_en = 1'b1;
          state_d  = ST_FETCH;
        end else begin
          cause_en = 1'b1;
          cause_d  = excm_q ? CAUSE_DOUBLE : CAUSE_TLB;
          state_d  = ST_FAULT;
        end
      end
      ST_FETCH: begin
        if (mem_req_ready) begin
          state_d = ST_AWAIT;
        end
      end
      ST_AWAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            cause_en = 1'b1;
            cause_d  = CAUSE_LOAD;
            state_d  = ST_FAULT;
          end else begin
            pte_en  = 1'b1;
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE:   state_d = ST_RESTART;
      ST_RESTART: state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/pte_refill_engine.sv
module pte_refill_engine
  import prf_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int RING_W     = 2,
  parameter int PAGE_LOG2  = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [VA_W-1:0]   miss_vaddr,
  input  logic              miss_excm,
  output logic              miss_ready,
  input  logic [VA_W-1:0]   pte_base,
  output logic              lk_req,
  output logic [VA_W-1:0]   lk_vaddr,
  output logic [RING_W-1:0] lk_ring,
  input  logic              lk_hit,
  input  logic [PA_W-1:0]   lk_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_addr,
  output logic [RING_W-1:0] mem_ring,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              tlb_wr_en,
  output logic [VA_W-1:0]   tlb_wr_vaddr,
  output logic [PTE_W-1:0]  tlb_wr_pte,
  output logic              restart,
  output logic              exc_tlb_miss,
  output logic              exc_double,
  output logic              exc_load_err
);
  localparam logic [RING_W-1:0] KERNEL_RING = '0;

  prf_state_e       state_q;
  prf_cause_e       cause_q;
  prf_cause_e       cause_d;
  logic             accept, paddr_en, pte_en, cause_en;
  logic [VA_W-1:0]  vaddr_q, base_q, pte_vaddr, page_vaddr;
  logic             excm_q;
  logic [PA_W-1:0]  paddr_q;
  logic [PTE_W-1:0] pte_q;
  logic             await_rsp;
  logic             in_fault;

  prf_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .lk_hit        (lk_hit),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .excm_q        (excm_q),
    .state_q       (state_q),
    .accept        (accept),
    .paddr_en      (paddr_en),
    .pte_en        (pte_en),
    .cause_en      (cause_en),
    .cause_d       (cause_d)
  );

  prf_capture #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .PTE_W (PTE_W)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .miss_vaddr (miss_vaddr),
    .miss_excm  (miss_excm),
    .pte_base   (pte_base),
    .paddr_en   (paddr_en),
    .lk_paddr   (lk_paddr),
    .pte_en     (pte_en),
    .rsp_data   (mem_rsp_data),
    .cause_en   (cause_en),
    .cause_d    (cause_d),
    .vaddr_q    (vaddr_q),
    .excm_q     (excm_q),
    .base_q     (base_q),
    .paddr_q    (paddr_q),
    .pte_q      (pte_q),
    .cause_q    (cause_q)
  );

  prf_addr_gen #(
    .VA_W       (VA_W),
    .PAGE_LOG2  (PAGE_LOG2),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_addr_gen (
    .base        (base_q),
    .fault_vaddr (vaddr_q),
    .pte_vaddr   (pte_vaddr),
    .page_vaddr  (page_vaddr)
  );

  always_comb begin
    in_fault      = (state_q == ST_FAULT);
    await_rsp     = (state_q == ST_AWAIT);
    miss_ready    = (state_q == ST_IDLE);
    lk_req        = (state_q == ST_XLATE);
    lk_vaddr      = pte_vaddr;
    lk_ring       = KERNEL_RING;
    mem_req_valid = (state_q == ST_FETCH);
    mem_addr      = paddr_q;
    mem_ring      = KERNEL_RING;
    tlb_wr_en     = (state_q == ST_WRITE);
    tlb_wr_vaddr  = page_vaddr;
    tlb_wr_pte    = pte_q;
    restart       = (state_q == ST_RESTART);
    exc_tlb_miss  = in_fault && (cause_q == CAUSE_TLB);
    exc_double    = in_fault && (cause_q == CAUSE_DOUBLE);
    exc_load_err  = in_fault && (cause_q == CAUSE_LOAD);
  end
endmodule

// File: rtl/prf_sva.sv
module prf_sva #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32,
  parameter int RING_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              lk_req,
  input logic [RING_W-1:0] lk_ring,
  input logic              lk_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_addr,
  input logic [RING_W-1:0] mem_ring,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic [PTE_W-1:0]  mem_rsp_data,
  input logic              await_rsp,
  input logic              tlb_wr_en,
  input logic [PTE_W-1:0]  tlb_wr_pte,
  input logic              restart,
  input logic              exc_tlb_miss,
  input logic              exc_double,
  input logic              exc_load_err
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !lk_req && !mem_req_valid && !tlb_wr_en && !restart);

  a_r2_lookup_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> lk_req && (lk_ring == '0));

  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  a_r3_read_ring_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_ring == '0));

  a_r4_miss_faults_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_hit |=> !mem_req_valid && (exc_tlb_miss || exc_double));

  a_r6_fill_then_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_en |=> restart);

  a_r6_fill_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && await_rsp && !mem_rsp_err |=> tlb_wr_en && (tlb_wr_pte == $past(mem_rsp_data)));

  a_r7_error_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && await_rsp && mem_rsp_err |=> exc_load_err && !tlb_wr_en);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req || mem_req_valid || await_rsp) |-> !miss_ready);

  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}));
endmodule

bind pte_refill_engine prf_sva #(
  .VA_W   (VA_W),
  .PA_W   (PA_W),
  .PTE_W  (PTE_W),
  .RING_W (RING_W)
) u_prf_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .lk_req        (lk_req),
  .lk_ring       (lk_ring),
  .lk_hit        (lk_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_ring      (mem_ring),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .mem_rsp_data  (mem_rsp_data),
  .await_rsp     (await_rsp),
  .tlb_wr_en     (tlb_wr_en),
  .tlb_wr_pte    (tlb_wr_pte),
  .restart       (restart),
  .exc_tlb_miss  (exc_tlb_miss),
  .exc_double    (exc_double),
  .exc_load_err  (exc_load_err)
);

// File: tb/test_pte_refill_engine.sv
`timescale 1ns/1ps
module test_pte_refill_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_excm = 1'b0;
  logic        miss_ready;
  logic [31:0] pte_base = '0;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_ring;
  logic        lk_hit = 1'b0;
  logic [31:0] lk_paddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_ring;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tlb_wr_en;
  logic [31:0] tlb_wr_vaddr;
  logic [31:0] tlb_wr_pte;
  logic        restart;
  logic        exc_tlb_miss;
  logic        exc_double;
  logic        exc_load_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int mem_accepts = 0;
  int wr_count = 0;
  int exc_count = 0;

  always #2.5 clk = ~clk;

  pte_refill_engine i_pte_refill_engine (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_excm(miss_excm),
    .miss_ready(miss_ready), .pte_base(pte_base),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_ring(lk_ring),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_ring(mem_ring),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vaddr(tlb_wr_vaddr), .tlb_wr_pte(tlb_wr_pte),
    .restart(restart), .exc_tlb_miss(exc_tlb_miss), .exc_double(exc_double),
    .exc_load_err(exc_load_err)
  );

  // Behavioural event counters observed on every edge.
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) mem_accepts++;
      if (tlb_wr_en) wr_count++;
      if (exc_tlb_miss || exc_double || exc_load_err) exc_count++;
      if ((32'(tlb_wr_en) + 32'(restart) + 32'(exc_tlb_miss) + 32'(exc_double) + 32'(exc_load_err)) > 1) begin
        checks++; fails++;
        $display("FAIL R10 several outcome pulses at once actual=%b expected=onehot0",
                 {tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_pte_addr(input logic [31:0] base, input logic [31:0] va);
    return base + ((va >> 10) & 32'hFFFF_FFFC);
  endfunction

  task automatic chk_quiet(input string req);
    chk(req, {27'd0, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'd0);
  endtask

  task automatic run_refill(input logic [31:0] va, input logic [31:0] base,
                            input logic excm, input logic hit,
                            input int rdly, input int rsp_dly,
                            input logic err, input logic [31:0] pte,
                            input logic noise);
    int acc0 = mem_accepts;
    int wr0  = wr_count;
    logic [31:0] pa = (va ^ 32'h5A5A_0000) & 32'hFFFF_FFFC;
    // idle cycle: offer the miss
    #1 chk("R1 ready in idle", {31'd0, miss_ready}, 32'd1);
    miss_valid = 1'b1; miss_vaddr = va; miss_excm = excm; pte_base = base;
    step();
    if (noise) begin
      miss_vaddr = va ^ 32'h0F0F_0000; miss_excm = ~excm; pte_base = base ^ 32'h0400_0000;
    end else begin
      miss_valid = 1'b0;
    end
    lk_hit = hit; lk_paddr = pa;
    #1;
    chk("R2 lookup request", {31'd0, lk_req}, 32'd1);
    chk("R2 lookup address", lk_vaddr, exp_pte_addr(base, va));
    chk("R2 lookup ring", {30'd0, lk_ring}, 32'd0);
    chk("R8 not ready while busy", {31'd0, miss_ready}, 32'd0);
    chk("R4 no read during lookup", {31'd0, mem_req_valid}, 32'd0);
    step();
    lk_hit = 1'b0;
    if (!hit) begin
      miss_valid = 1'b0;
      #1;
      chk(excm ? "R5 double exception" : "R4 miss exception", {30'd0, exc_tlb_miss, exc_double},
          excm ? 32'd1 : 32'd2);
      chk("R4 no read after miss", {31'd0, mem_req_valid}, 32'd0);
      chk("R4 no fill after miss", {29'd0, tlb_wr_en, restart, exc_load_err}, 32'd0);
      step();
      #1;
      chk("R1 ready after fault", {31'd0, miss_ready}, 32'd1);
      chk_quiet("R4 pulse is one cycle");
      chk("R4 no read issued", mem_accepts, acc0);
      return;
    end
    for (int i = 0; i < rdly; i++) begin
      mem_req_ready = 1'b0;
      #1;
      chk("R3 read held", {31'd0, mem_req_valid}, 32'd1);
      chk("R3 read address held", mem_addr, pa);
      step();
    end
    mem_req_ready = 1'b1;
    #1;
    chk("R3 read valid", {31'd0, mem_req_valid}, 32'd1);
    chk("R3 read address", mem_addr, pa);
    chk("R3 read ring", {30'd0, mem_ring}, 32'd0);
    step();
    mem_req_ready = 1'b0;
    for (int i = 0; i < rsp_dly; i++) begin
      #1;
      chk("R3 single read", {31'd0, mem_req_valid}, 32'd0);
      chk_quiet("R3 quiet while waiting");
      step();
    end
    mem_rsp_valid = 1'b1; mem_rsp_err = err; mem_rsp_data = pte;
    #1 chk_quiet("R6 no pulse before response taken");
    step();
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    if (err) begin
      miss_valid = 1'b0;
      #1;
      chk("R7 load error pulse", {27'd0, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'd1);
      step();
      #1;
      chk("R1 ready after load error", {31'd0, miss_ready}, 32'd1);
      chk("R7 no TLB write", wr_count, wr0);
      chk_quiet("R7 no restart");
      return;
    end
    #1;
    chk("R6 fill pulse", {27'd0, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'h10);
    chk("R6 fill page", tlb_wr_vaddr, va & 32'hFFFF_F000);
    chk("R6 fill entry", tlb_wr_pte, pte);
    step();
    miss_valid = 1'b0;
    #1;
    chk("R6 restart pulse", {27'd0, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'h08);
    step();
    #1;
    chk("R1 ready after restart", {31'd0, miss_ready}, 32'd1);
    chk_quiet("R6 restart is one cycle");
    chk("R3 exactly one read", mem_accepts, acc0 + 1);
  endtask

  task automatic stray_response(input logic err);
    int wr0 = wr_count;
    int ex0 = exc_count;
    mem_rsp_valid = 1'b1; mem_rsp_err = err; mem_rsp_data = 32'h1357_9BDF;
    step();
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    #1;
    chk("R9 stray response ignored", {27'd0, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'd0);
    chk("R9 still ready", {31'd0, miss_ready}, 32'd1);
    step();
    chk("R9 no write from stray", wr_count, wr0);
    chk("R9 no exception from stray", exc_count, ex0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ready", {31'd0, miss_ready}, 32'd1);
    chk("R1 reset quiet", {25'd0, lk_req, mem_req_valid, tlb_wr_en, restart, exc_tlb_miss, exc_double, exc_load_err}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    #1 chk("R1 ready after reset", {31'd0, miss_ready}, 32'd1);
    step();

    run_refill(32'h1234_5678, 32'hC000_0000, 1'b0, 1'b1, 0, 0, 1'b0, 32'hA000_1F03, 1'b0);
    run_refill(32'hFFFF_FFFC, 32'h0040_0000, 1'b0, 1'b1, 2, 3, 1'b0, 32'h0BAD_F00D, 1'b0);
    run_refill(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1, 0, 1'b0, 32'h0000_0003, 1'b0);
    run_refill(32'h8765_4321, 32'hFFC0_0000, 1'b0, 1'b0, 0, 0, 1'b0, 32'h0, 1'b0);
    run_refill(32'h8765_4321, 32'hFFC0_0000, 1'b1, 1'b0, 0, 0, 1'b0, 32'h0, 1'b0);
    run_refill(32'h4000_3FFF, 32'h2000_0000, 1'b1, 1'b1, 0, 1, 1'b0, 32'h7777_0001, 1'b0);
    run_refill(32'h6000_1000, 32'h1040_0000, 1'b0, 1'b1, 1, 2, 1'b1, 32'hFFFF_FFFF, 1'b0);
    run_refill(32'h2468_ACE0, 32'h0080_0000, 1'b0, 1'b1, 2, 1, 1'b0, 32'hCAFE_0005, 1'b1);
    run_refill(32'h0ABC_D000, 32'h0C00_0000, 1'b0, 1'b0, 0, 0, 1'b0, 32'h0, 1'b1);
    stray_response(1'b0);
    stray_response(1'b1);
    run_refill(32'h3333_3333, 32'h0400_0000, 1'b0, 1'b1, 0, 0, 1'b0, 32'h1111_2222, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule